// File: doc/BRIEF.md
# Dual-Issue Structural Hazard Checker

This block sits between decode and execute in a two-wide in-order core. Each cycle it is offered the two oldest decoded instructions, each tagged with a 4-bit class code. It decides whether the older one issues alone, the pair issues together, or nothing issues. The decision rests only on structural resources. These are the two integer pipes with unequal abilities, a single cache port, a floating-point block whose add, multiply and div/sqrt parts exclude each other, and the iterative multiply/divide and FP div/sqrt engines. Those engines stay occupied for many cycles after issue.

The two offer slots follow valid/ready rules. `opN_valid` marks an offered instruction, and `opN_grant` is its ready. A transfer happens in a cycle where both are high. An instruction that is offered but not granted must be offered again, unchanged, in the next cycle. Upstream must also move the younger instruction into slot 0 once the older one has gone. The grants are combinational from the current offer and the occupancy state. The occupancy counters change only on the rising clock edge and clear on synchronous reset.

Class codes: 0 arith, 1 shift, 2 load, 3 store, 4 fp load, 5 fp store, 6 branch, 7 int mul/div, 8 HI/LO move, 9 fp add-class, 10 fp multiply, 11 fp div/sqrt, 12 conditional move, 13 unknown/multi. Codes 14 and 15 are handled as unknown.

Top module: `issue_pair_arbiter`

## Requirements
- R1: With no occupancy pending, a valid slot-0 instruction of any class is granted in the same cycle. A slot whose valid is low is never granted.
- R2: Issue is in order. `op1_grant` is high only when `op0_grant` is high in the same cycle.
- R3: Shift (1), load (2), store (3), fp load (4) and fp store (5) each need integer pipe A. Two of them never issue as a pair.
- R4: Branch (6), int mul/div (7) and HI/LO move (8) each need integer pipe B. Two of them never pair. Arith (0) may use either pipe, so it pairs with arith, with any one pipe-A class, or with any one pipe-B class.
- R5: Loads, stores, fp loads and fp stores share one cache port. Two of them never pair.
- R6: After a store issues, no memory class is granted in the next 1 cycle. After an fp store issues, none is granted in the next 2 cycles. Classes that are not memory classes still issue during that time.
- R7: Conditional move (12) and unknown (13 to 15) issue alone. Granted in slot 0, they force `op1_grant` low. Offered in slot 1, they are not granted in that cycle.
- R8: A granted branch in slot 0 forces `op1_grant` low. A branch in slot 1 may pair with an older instruction that is not a branch.
- R9: Fp add-class (9), fp multiply (10) and fp div/sqrt (11) never pair with each other. Each pairs with integer and memory classes.
- R10: An int mul/div blocks further mul/div and HI/LO classes for IMD_HOLD cycles, counted from its issue cycle. A HI/LO move does the same for HILO_HOLD cycles. Arith and branch on pipe B still issue during that time.
- R11: An fp div/sqrt blocks further fp div/sqrt for FDIV_HOLD cycles, counted from its issue cycle. Fp add-class and multiply still issue during that time.
- R12: Synchronous reset clears all occupancy. The first cycle after reset grants any class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of occupancy state |
| op0_valid | input | 1 | Older instruction offered |
| op0_class | input | 4 | Class code of older instruction |
| op1_valid | input | 1 | Younger instruction offered |
| op1_class | input | 4 | Class code of younger instruction |
| op0_grant | output | 1 | Older instruction issues this cycle |
| op1_grant | output | 1 | Younger instruction issues this cycle |

## Verification
Pairing results are combinational. The grants respond within the same cycle as the offer, so the bench drives each offer just after a falling edge and samples the grants 1 time unit later, before the next rising edge. Occupancy results take effect from the first rising edge after the issuing cycle. A store therefore blocks exactly the next offer cycle, and an fp store blocks the next two. An int mul/div blocks the next IMD_HOLD-1 cycles, and the bench expects a grant on the offer IMD_HOLD cycles after issue. The same counting applies to HI/LO moves and fp div/sqrt. Each offer in the bench occupies exactly one clock period, so cycle counts in the checks map one-to-one onto counter steps.

// File: rtl/ih_pkg.sv
package ih_pkg;

  localparam int CLS_W = 4;

  typedef enum logic [CLS_W-1:0] {
    IC_ARITH  = 4'd0,
    IC_SHIFT  = 4'd1,
    IC_LOAD   = 4'd2,
    IC_STORE  = 4'd3,
    IC_FLOAD  = 4'd4,
    IC_FSTORE = 4'd5,
    IC_BRANCH = 4'd6,
    IC_IMD    = 4'd7,
    IC_HILO   = 4'd8,
    IC_FADD   = 4'd9,
    IC_FMUL   = 4'd10,
    IC_FDIV   = 4'd11,
    IC_CMOV   = 4'd12,
    IC_UNK    = 4'd13
  } iclass_e;

  // resource usage of one instruction
  typedef struct packed {
    logic need_a;
    logic need_b;
    logic flex;
    logic cache;
    logic fp;
    logic single;
    logic branch;
    logic st;
    logic fst;
    logic imd;
    logic hilo;
    logic fdiv;
  } use_t;

  function automatic int cnt_w(input int maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

  function automatic use_t decode_class(input logic [CLS_W-1:0] c);
    use_t u;
    u = '0;
    case (c)
      IC_ARITH:  u.flex = 1'b1;
      IC_SHIFT:  u.need_a = 1'b1;
      IC_LOAD:   begin u.need_a = 1'b1; u.cache = 1'b1; end
      IC_STORE:  begin u.need_a = 1'b1; u.cache = 1'b1; u.st = 1'b1; end
      IC_FLOAD:  begin u.need_a = 1'b1; u.cache = 1'b1; end
      IC_FSTORE: begin u.need_a = 1'b1; u.cache = 1'b1; u.fst = 1'b1; end
      IC_BRANCH: begin u.need_b = 1'b1; u.branch = 1'b1; end
      IC_IMD:    begin u.need_b = 1'b1; u.imd = 1'b1; end
      IC_HILO:   begin u.need_b = 1'b1; u.hilo = 1'b1; end
      IC_FADD:   u.fp = 1'b1;
      IC_FMUL:   u.fp = 1'b1;
      IC_FDIV:   begin u.fp = 1'b1; u.fdiv = 1'b1; end
      default:   u.single = 1'b1;
    endcase
    return u;
  endfunction

endpackage

// File: rtl/ih_slot_decode.sv
module ih_slot_decode
  import ih_pkg::*;
(
  input  logic [CLS_W-1:0] cls,
  output use_t             use_o
);

  always_comb use_o = decode_class(cls);

endmodule

// File: rtl/ih_pair_check.sv
module ih_pair_check (
  input  logic [1:0] need_a,
  input  logic [1:0] need_b,
  input  logic [1:0] flex,
  input  logic [1:0] cache,
  input  logic [1:0] fp,
  output logic       fit
);

  logic [1:0] a_cnt, b_cnt, f_cnt;
  logic [2:0] int_cnt;

  always_comb begin
    a_cnt   = {1'b0, need_a[0]} + {1'b0, need_a[1]};
    b_cnt   = {1'b0, need_b[0]} + {1'b0, need_b[1]};
    f_cnt   = {1'b0, flex[0]} + {1'b0, flex[1]};
    int_cnt = {1'b0, a_cnt} + {1'b0, b_cnt} + {1'b0, f_cnt};
    fit = (a_cnt <= 2'd1) && (b_cnt <= 2'd1) && (int_cnt <= 3'd2)
          && !(&cache) && !(&fp);
  end

endmodule

// File: rtl/ih_hold_timer.sv
module ih_hold_timer #(
  parameter int MAXV = 2,
  localparam int W = ih_pkg::cnt_w(MAXV)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R6 R10 R11: an occupant is only loaded once the unit has drained
  assert_load_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy);

  // R6 R10 R11: occupancy counts down one per cycle
  assert_count_down_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && !load) |=> (cnt == W'($past(cnt) - 1'b1)));

endmodule

// File: rtl/issue_pair_arbiter.sv
module issue_pair_arbiter
  import ih_pkg::*;
#(
  parameter int ST_EXTRA   = 1,
  parameter int FST_EXTRA  = 2,
  parameter int IMD_HOLD   = 7,
  parameter int HILO_HOLD  = 3,
  parameter int FDIV_HOLD  = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op0_valid,
  input  logic [CLS_W-1:0] op0_class,
  input  logic             op1_valid,
  input  logic [CLS_W-1:0] op1_class,
  output logic             op0_grant,
  output logic             op1_grant
);

  localparam int CMAX = (FST_EXTRA > ST_EXTRA) ? FST_EXTRA : ST_EXTRA;
  localparam int MMAX = (IMD_HOLD > HILO_HOLD) ? IMD_HOLD : HILO_HOLD;
  localparam int CW = cnt_w(CMAX);
  localparam int MW = cnt_w(MMAX);
  localparam int FW = cnt_w(FDIV_HOLD);

  use_t       u [2];
  logic [1:0] blocked;
  logic       pair_fit;
  logic       go0, go1;
  logic       cache_busy, md_busy, fd_busy;

  logic [CLS_W-1:0] cls [2];
  assign cls[0] = op0_class;
  assign cls[1] = op1_class;

  for (genvar i = 0; i < 2; i++) begin : g_slot
    ih_slot_decode u_dec (.cls(cls[i]), .use_o(u[i]));
    always_comb
      blocked[i] = (u[i].cache & cache_busy)
                 | ((u[i].imd | u[i].hilo) & md_busy)
                 | (u[i].fdiv & fd_busy);
  end

  ih_pair_check u_pair (
    .need_a ({u[1].need_a, u[0].need_a}),
    .need_b ({u[1].need_b, u[0].need_b}),
    .flex   ({u[1].flex,   u[0].flex}),
    .cache  ({u[1].cache,  u[0].cache}),
    .fp     ({u[1].fp,     u[0].fp}),
    .fit    (pair_fit)
  );

  always_comb begin
    go0 = op0_valid & ~blocked[0];
    go1 = go0 & op1_valid & ~blocked[1] & ~u[0].single & ~u[1].single
        & ~u[0].branch & pair_fit;
  end

  assign op0_grant = go0;
  assign op1_grant = go1;

  // occupancy loads
  logic          c_ld, m_ld, f_ld;
  logic [CW-1:0] c_val;
  logic [MW-1:0] m_val;
  logic [FW-1:0] f_val;
  logic          st_go, fst_go, imd_go, hilo_go, fdiv_go, mem_go;

  always_comb begin
    st_go   = (go0 & u[0].st)   | (go1 & u[1].st);
    fst_go  = (go0 & u[0].fst)  | (go1 & u[1].fst);
    imd_go  = (go0 & u[0].imd)  | (go1 & u[1].imd);
    hilo_go = (go0 & u[0].hilo) | (go1 & u[1].hilo);
    fdiv_go = (go0 & u[0].fdiv) | (go1 & u[1].fdiv);
    mem_go  = (go0 & u[0].cache) | (go1 & u[1].cache);
    c_ld  = st_go | fst_go;
    c_val = fst_go ? CW'(FST_EXTRA) : CW'(ST_EXTRA);
    m_ld  = imd_go | hilo_go;
    m_val = imd_go ? MW'(IMD_HOLD - 1) : MW'(HILO_HOLD - 1);
    f_ld  = fdiv_go;
    f_val = FW'(FDIV_HOLD - 1);
  end

  ih_hold_timer #(.MAXV(CMAX)) u_cache_t (
    .clk(clk), .rst(rst), .load(c_ld), .load_val(c_val), .busy(cache_busy));
  ih_hold_timer #(.MAXV(MMAX)) u_md_t (
    .clk(clk), .rst(rst), .load(m_ld), .load_val(m_val), .busy(md_busy));
  ih_hold_timer #(.MAXV(FDIV_HOLD)) u_fd_t (
    .clk(clk), .rst(rst), .load(f_ld), .load_val(f_val), .busy(fd_busy));

  assert_in_order_R2: assert property (@(posedge clk) disable iff (rst)
    op1_grant |-> op0_grant);

  assert_one_pipe_a_R3: assert property (@(posedge clk) disable iff (rst)
    op1_grant |-> !(u[0].need_a && u[1].need_a));

  assert_one_pipe_b_R4: assert property (@(posedge clk) disable iff (rst)
    op1_grant |-> !(u[0].need_b && u[1].need_b));

  assert_one_cache_R5: assert property (@(posedge clk) disable iff (rst)
    op1_grant |-> !(u[0].cache && u[1].cache));

  assert_store_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (st_go && ST_EXTRA > 0) |=> !mem_go);

  assert_solo_R7: assert property (@(posedge clk) disable iff (rst)
    (op0_grant && u[0].single) |-> !op1_grant);

  assert_branch_closes_R8: assert property (@(posedge clk) disable iff (rst)
    (op0_grant && u[0].branch) |-> !op1_grant);

  assert_young_branch_R8: assert property (@(posedge clk) disable iff (rst)
    (op1_grant && u[1].branch) |-> !u[0].branch);

  assert_fp_excl_R9: assert property (@(posedge clk) disable iff (rst)
    op1_grant |-> !(u[0].fp && u[1].fp));

  assert_md_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (imd_go && IMD_HOLD > 1) |=> !(op0_grant && (u[0].imd || u[0].hilo)));

  assert_fdiv_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (fdiv_go && FDIV_HOLD > 1) |=> !(op0_grant && u[0].fdiv));

endmodule

// File: tb/tb_issue_pair_arbiter.sv
module tb_issue_pair_arbiter;

  localparam int CLK_P     = 10;
  localparam int ST_X      = 1;
  localparam int FST_X     = 2;
  localparam int IMD_H     = 7;
  localparam int HILO_H    = 3;
  localparam int FDIV_H    = 17;

  localparam logic [3:0] C_ARITH = 4'd0, C_SHIFT = 4'd1, C_LOAD = 4'd2,
    C_STORE = 4'd3, C_FLOAD = 4'd4, C_FSTORE = 4'd5, C_BR = 4'd6,
    C_IMD = 4'd7, C_HILO = 4'd8, C_FADD = 4'd9, C_FMUL = 4'd10,
    C_FDIV = 4'd11, C_CMOV = 4'd12, C_UNK = 4'd13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic v0 = 1'b0, v1 = 1'b0;
  logic [3:0] c0 = '0, c1 = '0;
  logic g0, g1;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  issue_pair_arbiter #(
    .ST_EXTRA(ST_X), .FST_EXTRA(FST_X), .IMD_HOLD(IMD_H),
    .HILO_HOLD(HILO_H), .FDIV_HOLD(FDIV_H)
  ) dut (
    .clk(clk), .rst(rst),
    .op0_valid(v0), .op0_class(c0), .op1_valid(v1), .op1_class(c1),
    .op0_grant(g0), .op1_grant(g1)
  );

  // one offer per clock period: drive after falling edge, settle
  task automatic offer(input logic a_v, input logic [3:0] a_c,
                       input logic b_v, input logic [3:0] b_c);
    @(negedge clk);
    v0 = a_v; c0 = a_c; v1 = b_v; c1 = b_c;
    #1;
  endtask

  task automatic expect_g(input logic e0, input logic e1, input string tag);
    total++;
    if (g0 !== e0 || g1 !== e1) begin
      bad++;
      $display("FAIL %s: grants=%b%b expected=%b%b (classes %0d,%0d)",
               tag, g0, g1, e0, e1, c0, c1);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) offer(1'b0, '0, 1'b0, '0);
  endtask

  task automatic t_reset_R12;
    offer(1'b0, C_ARITH, 1'b0, C_ARITH);
    expect_g(1'b0, 1'b0, "R1 no valid no grant in reset");
    @(negedge clk); rst = 1'b0;
    offer(1'b1, C_STORE, 1'b0, C_ARITH);
    expect_g(1'b1, 1'b0, "R12 first cycle after reset");
    idle(2);
  endtask

  task automatic t_single_R1_R2;
    for (int c = 0; c < 14; c++) begin
      offer(1'b1, 4'(c), 1'b0, C_ARITH);
      expect_g(1'b1, 1'b0, $sformatf("R1 class %0d alone", c));
      idle(FDIV_H);
    end
    offer(1'b0, C_ARITH, 1'b1, C_ARITH);
    expect_g(1'b0, 1'b0, "R2 younger without older");
  endtask

  task automatic t_pipe_a_R3;
    offer(1'b1, C_SHIFT, 1'b1, C_SHIFT);
    expect_g(1'b1, 1'b0, "R3 shift+shift");
    offer(1'b1, C_SHIFT, 1'b1, C_LOAD);
    expect_g(1'b1, 1'b0, "R3 shift+load");
    offer(1'b1, C_LOAD, 1'b1, C_SHIFT);
    expect_g(1'b1, 1'b0, "R3 load+shift");
  endtask

  task automatic t_pipe_b_R4;
    offer(1'b1, C_IMD, 1'b1, C_BR);
    expect_g(1'b1, 1'b0, "R4 muldiv+branch");
    idle(IMD_H);
    offer(1'b1, C_ARITH, 1'b1, C_ARITH);
    expect_g(1'b1, 1'b1, "R4 arith+arith");
    offer(1'b1, C_ARITH, 1'b1, C_SHIFT);
    expect_g(1'b1, 1'b1, "R4 arith+shift");
    offer(1'b1, C_ARITH, 1'b1, C_IMD);
    expect_g(1'b1, 1'b1, "R4 arith+muldiv");
    idle(IMD_H);
    offer(1'b1, C_SHIFT, 1'b1, C_ARITH);
    expect_g(1'b1, 1'b1, "R4 shift+arith");
    offer(1'b1, C_SHIFT, 1'b1, C_HILO);
    expect_g(1'b1, 1'b1, "R4 shift+hilo");
    idle(HILO_H);
  endtask

  task automatic t_cache_R5;
    offer(1'b1, C_LOAD, 1'b1, C_FLOAD);
    expect_g(1'b1, 1'b0, "R5 load+fpload");
    offer(1'b1, C_LOAD, 1'b1, C_FADD);
    expect_g(1'b1, 1'b1, "R5 load+fadd pairs");
  endtask

  task automatic t_store_R6;
    offer(1'b1, C_STORE, 1'b0, C_ARITH);
    expect_g(1'b1, 1'b0, "R6 store issues");
    offer(1'b1, C_ARITH, 1'b1, C_LOAD);
    expect_g(1'b1, 1'b0, "R6 load blocked after store, arith ok");
    offer(1'b1, C_LOAD, 1'b0, C_ARITH);
    expect_g(1'b1, 1'b0, "R6 load after store hold");
    offer(1'b1, C_FSTORE, 1'b0, C_ARITH);
    expect_g(1'b1, 1'b0, "R6 fp store issues");
    offer(1'b1, C_LOAD, 1'b0, C_ARITH);
    expect_g(1'b0, 1'b0, "R6 fp store hold 1");
    offer(1'b1, C_STORE, 1'b0, C_ARITH);
    expect_g(1'b0, 1'b0, "R6 fp store hold 2");
    offer(1'b1, C_LOAD, 1'b0, C_ARITH);
    expect_g(1'b1, 1'b0, "R6 load after fp store hold");
  endtask

  task automatic t_solo_R7;
    offer(1'b1, C_CMOV, 1'b1, C_ARITH);
    expect_g(1'b1, 1'b0, "R7 cmov alone");
    offer(1'b1, C_ARITH, 1'b1, C_UNK);
    expect_g(1'b1, 1'b0, "R7 unknown in slot1");
    offer(1'b1, 4'd15, 1'b1, C_FADD);
    expect_g(1'b1, 1'b0, "R7 code 15 alone");
  endtask

  task automatic t_branch_R8;
    offer(1'b1, C_BR, 1'b1, C_ARITH);
    expect_g(1'b1, 1'b0, "R8 branch closes group");
    offer(1'b1, C_ARITH, 1'b1, C_BR);
    expect_g(1'b1, 1'b1, "R8 branch in slot1");
  endtask

  task automatic t_fp_R9;
    offer(1'b1, C_FADD, 1'b1, C_FMUL);
    expect_g(1'b1, 1'b0, "R9 fadd+fmul");
    offer(1'b1, C_FMUL, 1'b1, C_FADD);
    expect_g(1'b1, 1'b0, "R9 fmul+fadd");
    offer(1'b1, C_FMUL, 1'b1, C_SHIFT);
    expect_g(1'b1, 1'b1, "R9 fmul+shift");
  endtask

  task automatic t_md_R10;
    offer(1'b1, C_IMD, 1'b0, C_ARITH);
    expect_g(1'b1, 1'b0, "R10 muldiv issues");
    offer(1'b1, C_BR, 1'b0, C_ARITH);
    expect_g(1'b1, 1'b0, "R10 branch during muldiv");
    for (int k = 2; k < IMD_H; k++) begin
      offer(1'b1, (k == 2) ? C_HILO : C_IMD, 1'b0, C_ARITH);
      expect_g(1'b0, 1'b0, $sformatf("R10 muldiv held cycle %0d", k));
    end
    offer(1'b1, C_HILO, 1'b0, C_ARITH);
    expect_g(1'b1, 1'b0, "R10 hilo after muldiv hold");
    for (int k = 1; k < HILO_H; k++) begin
      offer(1'b1, C_IMD, 1'b1, C_ARITH);
      expect_g(1'b0, 1'b0, $sformatf("R10 hilo held cycle %0d", k));
    end
    offer(1'b1, C_IMD, 1'b0, C_ARITH);
    expect_g(1'b1, 1'b0, "R10 muldiv after hilo hold");
    idle(IMD_H);
  endtask

  task automatic t_fdiv_R11_R12;
    offer(1'b1, C_FDIV, 1'b0, C_ARITH);
    expect_g(1'b1, 1'b0, "R11 fdiv issues");
    offer(1'b1, C_FADD, 1'b0, C_ARITH);
    expect_g(1'b1, 1'b0, "R11 fadd during fdiv");
    for (int k = 2; k < FDIV_H; k++) begin
      offer(1'b1, C_FDIV, 1'b0, C_ARITH);
      expect_g(1'b0, 1'b0, $sformatf("R11 fdiv held cycle %0d", k));
    end
    offer(1'b1, C_FDIV, 1'b0, C_ARITH);
    expect_g(1'b1, 1'b0, "R11 fdiv after hold");
    @(negedge clk); v0 = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    offer(1'b1, C_FDIV, 1'b0, C_ARITH);
    expect_g(1'b1, 1'b0, "R12 reset clears fdiv hold");
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset_R12();
    t_single_R1_R2();
    t_pipe_a_R3();
    t_pipe_b_R4();
    t_cache_R5();
    t_store_R6();
    t_solo_R7();
    t_branch_R8();
    t_fp_R9();
    t_md_R10();
    t_fdiv_R11_R12();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule